// File: doc/BRIEF.md
# Host-Clocked Byte Readout Port

This block sits after a serial deframer. It holds the most recent received byte and lets an external host read it out one bit at a time. When a byte arrives, the block drives an active-low ready strobe low to mark the byte boundary. The host then toggles its own clock line. On each rising edge of that clock, the block moves the serial output to the next bit, least significant bit first.

The host clock is asynchronous to the system clock. It passes through a synchroniser chain, and its rising edges are detected in the system-clock domain. The ready strobe returns high on the first host rising edge. If no host edge arrives, it returns high by itself after a half-bit timeout, which is given as a count of system-clock cycles. Host edges after the whole byte has been read change nothing. A byte that arrives before the previous one has been fully read replaces it, and this is reported with a one-cycle overrun pulse.

Top module: `byte_readout_port`

## Requirements
- R1: During and after reset, and before any byte is loaded, `ready_n` is 1, `ser_out` is 1 and `overrun` is 0.
- R2: On the cycle after `byte_vld` is sampled high, `ready_n` is 0 and `ser_out` equals bit 0 of the loaded byte.
- R3: While `ready_n` is 0, the first rising edge of `host_clk` returns `ready_n` to 1. With two synchroniser stages, the change is visible after the third system clock edge after `host_clk` rises.
- R4: If no host rising edge arrives, `ready_n` stays 0 for exactly `HALF_BIT_CYC` system cycles after a load, and then returns to 1.
- R5: The k-th host rising edge after a load (k = 1..7) sets `ser_out` to bit k of the byte. Bits come out in LSB-first order, with the same latency as in R3.
- R6: The eighth and any later host rising edges after a load leave `ser_out` at bit 7. They do not change `ready_n`.
- R7: If `byte_vld` arrives before eight host edges have followed the previous load, the block gives a one-cycle `overrun` pulse on the next cycle. The new byte replaces the old one and the readout restarts at bit 0. A load into an idle or fully read port gives no pulse.
- R8: Only rising edges of `host_clk` count. A level held high over many cycles advances the readout once, and a falling edge advances nothing.
- R9: If a load and a detected host rising edge fall in the same cycle, the load wins. `ready_n` goes to 0, `ser_out` shows bit 0 of the new byte, and that edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_in | input | DATA_W | Received byte from the deframer |
| byte_vld | input | 1 | One-cycle strobe: `byte_in` holds a new byte |
| host_clk | input | 1 | Host read clock, asynchronous |
| ser_out | output | 1 | Serial data bit presented to the host |
| ready_n | output | 1 | Active-low byte-ready strobe |
| overrun | output | 1 | One-cycle pulse: an unread byte was replaced |

## Verification
Some properties are checked by the assertions on every cycle. The ready strobe falls only after a load. It clears on the first detected host edge. It never stays low longer than the timeout. The serial output shows bit 0 right after a load and stays still once the last bit is presented. An overrun pulse always follows a load.

Other behaviour only the bench scenarios can show. These cover the full LSB-first bit order for several byte patterns, and the exact length of the timeout. They also cover the restart at bit 0 after an overrun, the single advance for a host clock held high, and the priority of a load over a host edge in the same cycle.

// File: rtl/brp_pkg.sv
package brp_pkg;

   // Width needed to hold values 0..n
   function automatic int cnt_w(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

   typedef enum logic [1:0] {
      RD_IDLE    = 2'd0,
      RD_SHIFT   = 2'd1,
      RD_DRAINED = 2'd2
   } rd_state_t;

endpackage

// File: rtl/brp_edge_sync.sv
module brp_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              prev_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= async_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/brp_shifter.sv
module brp_shifter
   import brp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              adv,
   output logic              ser,
   output logic              busy
);
   localparam int IDX_W = cnt_w(DATA_W);

   logic [DATA_W-1:0] hold_q;
   logic [IDX_W-1:0]  edges_q;
   rd_state_t         st;

   always_comb begin
      if (edges_q == IDX_W'(DATA_W))  st = RD_DRAINED;
      else if (edges_q == '0)         st = RD_IDLE;
      else                            st = RD_SHIFT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q  <= '1;
         edges_q <= IDX_W'(DATA_W);
      end else if (load) begin
         hold_q  <= din;
         edges_q <= '0;
      end else if (adv && st != RD_DRAINED) begin
         edges_q <= edges_q + 1'b1;
         if (edges_q < IDX_W'(DATA_W - 1))
            hold_q <= {1'b1, hold_q[DATA_W-1:1]};
      end
   end

   assign ser  = hold_q[0];
   assign busy = (st != RD_DRAINED);
endmodule

// File: rtl/brp_ready_timer.sv
module brp_ready_timer
   import brp_pkg::*;
#(
   parameter int HALF_BIT_CYC = 20833
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic edge_seen,
   output logic ready_n
);
   localparam int TW = cnt_w(HALF_BIT_CYC);

   logic [TW-1:0] left_q;
   logic          rdy_n_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n_q <= 1'b1;
         left_q  <= '0;
      end else if (load) begin
         rdy_n_q <= 1'b0;
         left_q  <= TW'(HALF_BIT_CYC);
      end else if (!rdy_n_q) begin
         if (edge_seen || left_q == TW'(1)) begin
            rdy_n_q <= 1'b1;
            left_q  <= '0;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign ready_n = rdy_n_q;
endmodule

// File: rtl/byte_readout_port.sv
module byte_readout_port #(
   parameter int DATA_W       = 8,
   parameter int HALF_BIT_CYC = 20833,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              byte_vld,
   input  logic              host_clk,
   output logic              ser_out,
   output logic              ready_n,
   output logic              overrun
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (HALF_BIT_CYC < 2) begin : g_bad_t
         $error("HALF_BIT_CYC must be at least 2");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_s
         $error("SYNC_STAGES must be 1..4");
      end
   endgenerate

   logic host_rise;
   logic busy;
   logic ovr_q;

   brp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (host_clk),
      .rise     (host_rise)
   );

   brp_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (byte_vld),
      .din   (byte_in),
      .adv   (host_rise),
      .ser   (ser_out),
      .busy  (busy)
   );

   brp_ready_timer #(.HALF_BIT_CYC(HALF_BIT_CYC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (byte_vld),
      .edge_seen (host_rise),
      .ready_n   (ready_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ovr_q <= 1'b0;
      else        ovr_q <= byte_vld & busy;
   end

   assign overrun = ovr_q;
endmodule

// File: rtl/brp_checker.sv
module brp_checker
   import brp_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int HALF_BIT_CYC = 20833
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] byte_in,
   input logic              byte_vld,
   input logic              rise,
   input logic              ser_out,
   input logic              ready_n,
   input logic              overrun
);
   localparam int LW = cnt_w(HALF_BIT_CYC + 1);
   localparam int EW = cnt_w(DATA_W);

   logic [LW-1:0] low_cnt;
   logic [EW-1:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt  <= '0;
         edge_cnt <= EW'(DATA_W);
      end else begin
         if (byte_vld)                               low_cnt <= LW'(1);
         else if (!ready_n && low_cnt <= LW'(HALF_BIT_CYC)) low_cnt <= low_cnt + 1'b1;
         else if (ready_n)                           low_cnt <= '0;

         if (byte_vld)                               edge_cnt <= '0;
         else if (rise && edge_cnt < EW'(DATA_W))    edge_cnt <= edge_cnt + 1'b1;
      end
   end

   // R2: a load pulls the strobe low and shows bit 0
   p_load_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> (!ready_n && ser_out == $past(byte_in[0])));

   // R2: the strobe only falls after a load
   p_fall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_n) |-> $past(byte_vld));

   // R3: first host edge clears the strobe
   p_edge_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !byte_vld && !ready_n) |=> ready_n);

   // R4: strobe low no longer than the timeout
   p_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ready_n |-> (low_cnt <= LW'(HALF_BIT_CYC)));

   // R6: once bit 7 is shown, the output holds until the next load
   p_drained_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!byte_vld && edge_cnt >= EW'(DATA_W - 1)) |=> $stable(ser_out));

   // R7: overrun only follows a load
   p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(byte_vld));
endmodule

bind byte_readout_port brp_checker #(
   .DATA_W       (DATA_W),
   .HALF_BIT_CYC (HALF_BIT_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .byte_in  (byte_in),
   .byte_vld (byte_vld),
   .rise     (host_rise),
   .ser_out  (ser_out),
   .ready_n  (ready_n),
   .overrun  (overrun)
);

// File: tb/sim_byte_readout_port.sv
`timescale 1ns/1ps
module sim_byte_readout_port;
   localparam int DW = 8;
   localparam int HB = 20;
   localparam int NV = 4;
   // stimulus byte and expected serial order (bit k on edge k), LSB first
   localparam logic [DW-1:0] VEC_BYTE [NV] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
   localparam logic [DW-1:0] VEC_EXP  [NV] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] byte_in = '0;
   logic byte_vld = 1'b0;
   logic host_clk = 1'b0;
   logic ser_out, ready_n, overrun;
   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   byte_readout_port #(.DATA_W(DW), .HALF_BIT_CYC(HB), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .byte_in(byte_in), .byte_vld(byte_vld),
      .host_clk(host_clk), .ser_out(ser_out), .ready_n(ready_n), .overrun(overrun)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_byte(input logic [DW-1:0] b);
      @(negedge clk);
      byte_in  = b;
      byte_vld = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   // raise host clock, wait until its edge has acted, then lower it
   task automatic host_up;
      host_clk = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic host_down;
      host_clk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] b;
      int lowc;
      repeat (3) @(negedge clk);
      chk("R1 ready_n in reset", ready_n, 1);
      chk("R1 ser_out in reset", ser_out, 1);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 ready_n idle", ready_n, 1);
      chk("R1 overrun idle", overrun, 0);

      // table-driven readout
      for (int v = 0; v < NV; v++) begin
         load_byte(VEC_BYTE[v]);
         chk("R2 ready_n low after load", ready_n, 0);
         chk("R2 bit0 after load", ser_out, VEC_EXP[v][0]);
         chk("R7 no overrun on idle load", overrun, 0);
         for (int k = 1; k <= DW; k++) begin
            host_up();
            if (k == 1) chk("R3 first edge clears ready", ready_n, 1);
            if (k < DW) chk("R5 bit order", ser_out, VEC_EXP[v][k]);
            else        chk("R6 eighth edge holds bit7", ser_out, VEC_EXP[v][DW-1]);
            host_down();
         end
         for (int e = 0; e < 2; e++) begin
            host_up();
            chk("R6 extra edge ignored ser_out", ser_out, VEC_EXP[v][DW-1]);
            chk("R6 extra edge ignored ready_n", ready_n, 1);
            host_down();
         end
      end

      // R4 timeout length, R7 no overrun after full read
      load_byte(8'h5A);
      chk("R7 no overrun after full read", overrun, 0);
      lowc = 0;
      while (ready_n == 1'b0 && lowc < 1000) begin
         lowc++;
         @(negedge clk);
      end
      chk("R4 timeout cycles", lowc, HB);
      chk("R4 ser_out kept after timeout", ser_out, 0);

      // R7 overrun: partial read then new byte
      host_up(); host_down();
      host_up(); host_down();
      b = 8'hC6;
      load_byte(b);
      chk("R7 overrun pulse", overrun, 1);
      chk("R7 restart at bit0", ser_out, b[0]);
      @(negedge clk);
      chk("R7 overrun one cycle", overrun, 0);

      // R8 long high level advances once, falling edge nothing
      host_clk = 1'b1;
      repeat (12) @(negedge clk);
      chk("R8 held high advances once", ser_out, b[1]);
      host_down();
      repeat (4) @(negedge clk);
      chk("R8 falling edge no advance", ser_out, b[1]);

      // R9 load coinciding with detected edge
      b = 8'h92;
      host_clk = 1'b1;
      @(negedge clk);
      @(negedge clk);
      byte_in  = b;
      byte_vld = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0;
      chk("R9 load wins ready_n", ready_n, 0);
      chk("R9 load wins ser_out", ser_out, b[0]);
      chk("R9 overrun on partial", overrun, 1);
      host_down();
      chk("R9 edge not counted", ser_out, b[0]);
      host_up();
      chk("R9 next edge gives bit1", ser_out, b[1]);
      host_down();

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule